// File: doc/BRIEF.md
# Two-Phase Pipeline Stage Controller

This block is the control element of one self-timed pipeline stage that uses two-phase bundled-data signalling. Every transfer runs over one request wire and one acknowledge wire. An event is a change of level on a wire, in either direction. A join (C-element) combines the delayed incoming request with the acknowledge that comes back from the next stage. When the join changes state, the stage's word register captures the bundled data and the upstream acknowledge flips. A toggle element then turns each join event into a flip of a capture/pass level, and that level drives the latches of this stage only.

The model is synchronous. A fast sampling clock watches the wires, so the stage can be synthesized and simulated. A configurable number of sample cycles on the request path stands in for the matched delay of the bundle. The data word must be stable before the delayed request reaches the join, and it must stay stable until the acknowledge flips. The outgoing request can come from the toggle output, which is safe and adds one cycle, or straight from the join, which shortens the stage cycle. A synchronous clear returns the delay line, the join, the toggle and the word register to their known state. Adjacent stages start their capture/pass levels in opposite phases, so when one set of latches is transparent the next set is opaque.

Top module: `mp_stage_ctrl`

## Requirements
- R1: After reset, `ack_o` and `req_o` are 0, `data_o` is all zeros and `cap_o` equals the parameter `CAP_INIT`.
- R2: If the stage is idle (`ack_i` equals `req_o` and no event is outstanding), an event on `req_i` flips `ack_o` exactly `REQ_DLY`+1 clock cycles later.
- R3: With `REQ_SRC` = `REQ_FROM_JOIN` (encoding 1), `req_o` flips in the same cycle as `ack_o`. With `REQ_SRC` = `REQ_VIA_TOGGLE` (encoding 0), `req_o` flips exactly one cycle after `ack_o`.
- R4: While the last outgoing request is not yet acknowledged (`ack_i` differs from the join state), no new request is accepted and `ack_o`, `req_o` and `data_o` hold. Once `ack_i` flips, a request that is already waiting is accepted on the next clock edge.
- R5: `cap_o` flips exactly once per accepted event, one cycle after `ack_o` flips, and stays unchanged otherwise.
- R6: `ack_o` flips only to match the delayed request, so every request event produces exactly one acknowledge event.
- R7: `data_o` loads `data_i` in the cycle `ack_o` flips and keeps its value in every other cycle except a clear.
- R8: A clear (`clr_i` = 1 at a clock edge) takes priority over a join event at the same edge. It leaves `ack_o` = 0, `req_o` = 0, `cap_o` = `CAP_INIT` and `data_o` = 0, and it also empties the request delay line.
- R9: In a chain of stages, with random acknowledge latency at the end, every word arrives once, in order, and unchanged.
- R10: Stages built with alternating `CAP_INIT` values present opposite capture/pass phases after reset. They present opposite phases again once the chain has drained.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of the stage control state |
| req_i | input | 1 | Incoming request wire, one event per word |
| data_i | input | DATA_W | Bundled data word from the upstream stage |
| ack_o | output | 1 | Upstream acknowledge wire |
| req_o | output | 1 | Outgoing request wire |
| data_o | output | DATA_W | Captured word, offered to the downstream stage |
| ack_i | input | 1 | Acknowledge wire from the downstream stage |
| cap_o | output | 1 | Capture/pass level for this stage's latches |

## Verification
Two functions can land on the same clock edge: a clear, and the join accepting a request. The bench raises `clr_i` in exactly the cycle in which the delayed request reaches the join. It does this once for a stage with no request delay and once for a stage with a two-cycle delay. The result is judged correct only if every output shows its cleared value one cycle later and no late acceptance appears afterwards. A second case flips the downstream acknowledge in the same cycle as a new request event. It checks that each stage variant accepts the word exactly at its own delay.

// File: rtl/mp_stage_pkg.sv
package mp_stage_pkg;

  // source of the outgoing request wire
  typedef enum logic {
    REQ_VIA_TOGGLE = 1'b0,
    REQ_FROM_JOIN  = 1'b1
  } req_src_e;

  // C-element fed with the request and the inverted acknowledge
  function automatic logic c_join(input logic req, input logic ack, input logic prev);
    return (req != ack) ? req : prev;
  endfunction

endpackage

// File: rtl/mp_req_delay.sv
module mp_req_delay #(
  parameter int unsigned DLY = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic req_i,
  output logic req_o
);

  if (DLY == 0) begin : g_none
    logic unused_pins;
    assign unused_pins = clk_i ^ rst_ni ^ clr_i;
    assign req_o = req_i;
  end else begin : g_line
    logic [DLY-1:0] sh_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_q <= '0;
      end else if (clr_i) begin
        sh_q <= '0;
      end else begin
        sh_q[0] <= req_i;
        for (int i = 1; i < DLY; i++) sh_q[i] <= sh_q[i-1];
      end
    end

    assign req_o = sh_q[DLY-1];

    p_line_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (req_o == 1'b0));
  end

endmodule

// File: rtl/mp_c_join.sv
module mp_c_join
  import mp_stage_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic req_i,
  input  logic ack_i,
  output logic c_o,
  output logic fire_o
);

  logic c_q;
  logic c_d;

  always_comb c_d = c_join(req_i, ack_i, c_q);

  assign fire_o = !clr_i && (c_d != c_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     c_q <= 1'b0;
    else if (clr_i)  c_q <= 1'b0;
    else             c_q <= c_d;
  end

  assign c_o = c_q;

  // waiting on downstream: join state frozen
  p_hold_until_ack_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_q != ack_i) && !clr_i |=> $stable(c_q));

  // join moves only toward the request
  p_join_to_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && (c_q == req_i) |=> $stable(c_q));

endmodule

// File: rtl/mp_toggle.sv
module mp_toggle #(
  parameter bit INIT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic in_i,
  output logic t_o
);

  logic in_q;
  logic t_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q <= 1'b0;
      t_q  <= INIT;
    end else if (clr_i) begin
      in_q <= 1'b0;
      t_q  <= INIT;
    end else begin
      in_q <= in_i;
      if (in_i != in_q) t_q <= ~t_q;
    end
  end

  assign t_o = t_q;

  p_one_flip_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && (in_i != in_q) |=> (t_q != $past(t_q)));

  p_no_flip_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && (in_i == in_q) |=> $stable(t_q));

endmodule

// File: rtl/mp_word_reg.sv
module mp_word_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         cap_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= '0;
    else if (clr_i)  q_q <= '0;
    else if (cap_i)  q_q <= d_i;
  end

  assign q_o = q_q;

endmodule

// File: rtl/mp_stage_ctrl.sv
module mp_stage_ctrl
  import mp_stage_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned REQ_DLY = 2,
  parameter req_src_e    REQ_SRC = REQ_VIA_TOGGLE,
  parameter bit          CAP_INIT = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              req_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ack_o,
  output logic              req_o,
  output logic [DATA_W-1:0] data_o,
  input  logic              ack_i,
  output logic              cap_o
);

  logic req_d;
  logic join_q;
  logic join_fire;
  logic tgl;

  mp_req_delay #(.DLY(REQ_DLY)) u_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_i),
    .req_i (req_i),
    .req_o (req_d)
  );

  mp_c_join u_join (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_i),
    .req_i (req_d),
    .ack_i (ack_i),
    .c_o   (join_q),
    .fire_o(join_fire)
  );

  mp_toggle #(.INIT(CAP_INIT)) u_tgl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_i),
    .in_i  (join_q),
    .t_o   (tgl)
  );

  mp_word_reg #(.W(DATA_W)) u_word (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_i),
    .cap_i (join_fire),
    .d_i   (data_i),
    .q_o   (data_o)
  );

  assign ack_o = join_q;
  assign cap_o = tgl;

  if (REQ_SRC == REQ_FROM_JOIN) begin : g_fast
    assign req_o = join_q;
  end else begin : g_safe
    // toggle output re-based to a zero start
    assign req_o = tgl ^ CAP_INIT;

    p_req_lag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clr_i && (ack_o != req_o) |=> (req_o == $past(ack_o)));
  end

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !ack_o && !req_o && (cap_o == CAP_INIT) && (data_o == '0));

  p_ack_follows_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!clr_i) && !$stable(ack_o) |-> (ack_o == $past(req_d)));

  p_fire_ready_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!clr_i) && !$stable(ack_o) |-> ($past(ack_i) == $past(ack_o)));

  p_data_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!clr_i) && $stable(ack_o) |-> $stable(data_o));

endmodule

// File: tb/test_mp_stage_ctrl.sv
`timescale 1ns/1ps
module test_mp_stage_ctrl;
  import mp_stage_pkg::*;

  localparam int unsigned W       = 16;
  localparam int unsigned N_WORDS = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit fin = 1'b0;

  // directed pair: safe/delayed and fast/undelayed
  logic         s_clr = 1'b0, s_req = 1'b0, s_ack = 1'b0;
  logic [W-1:0] s_data = '0;
  logic         sl_ack, sl_req, sl_cap, fa_ack, fa_req, fa_cap;
  logic [W-1:0] sl_data, fa_data;

  mp_stage_ctrl #(.DATA_W(W), .REQ_DLY(2), .REQ_SRC(REQ_VIA_TOGGLE), .CAP_INIT(1'b0)) i_mp_stage_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(s_clr), .req_i(s_req), .data_i(s_data),
    .ack_o(sl_ack), .req_o(sl_req), .data_o(sl_data), .ack_i(s_ack), .cap_o(sl_cap));

  mp_stage_ctrl #(.DATA_W(W), .REQ_DLY(0), .REQ_SRC(REQ_FROM_JOIN), .CAP_INIT(1'b1)) i_fast (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(s_clr), .req_i(s_req), .data_i(s_data),
    .ack_o(fa_ack), .req_o(fa_req), .data_o(fa_data), .ack_i(s_ack), .cap_o(fa_cap));

  // three-stage chain
  logic         k_clr = 1'b0, k_req = 1'b0, k_ack = 1'b0;
  logic [W-1:0] k_data = '0;
  logic         kr0, kr1, kr2, ka0, ka1, ka2, kc0, kc1, kc2;
  logic [W-1:0] kd0, kd1, kd2;

  mp_stage_ctrl #(.DATA_W(W), .REQ_DLY(1), .REQ_SRC(REQ_FROM_JOIN), .CAP_INIT(1'b0)) u_k0 (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(k_clr), .req_i(k_req), .data_i(k_data),
    .ack_o(ka0), .req_o(kr0), .data_o(kd0), .ack_i(ka1), .cap_o(kc0));
  mp_stage_ctrl #(.DATA_W(W), .REQ_DLY(0), .REQ_SRC(REQ_VIA_TOGGLE), .CAP_INIT(1'b1)) u_k1 (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(k_clr), .req_i(kr0), .data_i(kd0),
    .ack_o(ka1), .req_o(kr1), .data_o(kd1), .ack_i(ka2), .cap_o(kc1));
  mp_stage_ctrl #(.DATA_W(W), .REQ_DLY(2), .REQ_SRC(REQ_FROM_JOIN), .CAP_INIT(1'b0)) u_k2 (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(k_clr), .req_i(kr1), .data_i(kd1),
    .ack_o(ka2), .req_o(kr2), .data_o(kd2), .ack_i(k_ack), .cap_o(kc2));

  task automatic ck(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!fin) begin
      fin = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_chk++;
      n_bad++;
      $display("FAIL R9 watchdog act=timeout exp=drained");
      finish_run();
    end
  end

  // scoreboard sink at the chain end
  logic [W-1:0] exp_q[$];
  bit run_k = 1'b0;
  int n_rcv = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (run_k && (kr2 !== k_ack)) begin
        if (exp_q.size() == 0) begin
          ck("R9 duplicate word", 32'(kd2), 32'hFFFF_FFFF);
        end else begin
          logic [W-1:0] e;
          e = exp_q.pop_front();
          ck("R9 word order", 32'(kd2), 32'(e));
        end
        n_rcv++;
        repeat ($urandom_range(0, 5)) @(negedge clk);
        k_ack = kr2;
      end
    end
  end

  // acknowledge events of the first chain stage
  int   n_ack0 = 0;
  logic ka0_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (ka0 !== ka0_prev) n_ack0++;
      ka0_prev = ka0;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    ck("R1 slow ack", 32'(sl_ack), 0);
    ck("R1 slow req", 32'(sl_req), 0);
    ck("R1 slow cap", 32'(sl_cap), 0);
    ck("R1 slow data", 32'(sl_data), 0);
    ck("R1 fast ack", 32'(fa_ack), 0);
    ck("R1 fast req", 32'(fa_req), 0);
    ck("R1 fast cap", 32'(fa_cap), 1);
    ck("R10 reset phases", 32'({kc0, kc1, kc2}), 32'b010);

    // idle transfer
    s_req = 1'b1; s_data = 16'hA5C3;
    step(1);
    ck("R2 fast ack after 1", 32'(fa_ack), 1);
    ck("R3 fast req with ack", 32'(fa_req), 1);
    ck("R7 fast data", 32'(fa_data), 32'hA5C3);
    ck("R5 fast cap not yet", 32'(fa_cap), 1);
    ck("R2 slow ack early", 32'(sl_ack), 0);
    step(1);
    ck("R5 fast cap flipped", 32'(fa_cap), 0);
    ck("R2 slow ack still early", 32'(sl_ack), 0);
    step(1);
    ck("R2 slow ack after 3", 32'(sl_ack), 1);
    ck("R7 slow data", 32'(sl_data), 32'hA5C3);
    ck("R3 slow req lags", 32'(sl_req), 0);
    ck("R5 slow cap not yet", 32'(sl_cap), 0);
    step(1);
    ck("R3 slow req", 32'(sl_req), 1);
    ck("R5 slow cap flipped", 32'(sl_cap), 1);

    // back-pressure
    s_req = 1'b0; s_data = 16'h0F1E;
    step(6);
    ck("R4 fast ack held", 32'(fa_ack), 1);
    ck("R4 slow ack held", 32'(sl_ack), 1);
    ck("R4 fast data held", 32'(fa_data), 32'hA5C3);
    ck("R4 slow data held", 32'(sl_data), 32'hA5C3);
    ck("R5 fast cap held", 32'(fa_cap), 0);
    ck("R5 slow cap held", 32'(sl_cap), 1);
    s_ack = 1'b1;
    step(1);
    ck("R4 fast released", 32'(fa_ack), 0);
    ck("R4 slow released", 32'(sl_ack), 0);
    ck("R7 fast new data", 32'(fa_data), 32'h0F1E);
    ck("R7 slow new data", 32'(sl_data), 32'h0F1E);
    ck("R3 fast req", 32'(fa_req), 0);
    ck("R3 slow req lags", 32'(sl_req), 1);
    step(1);
    ck("R3 slow req", 32'(sl_req), 0);
    ck("R5 fast cap back", 32'(fa_cap), 1);
    ck("R5 slow cap back", 32'(sl_cap), 0);
    s_ack = 1'b0;
    step(2);

    // clear on the fast stage's accepting edge
    s_req = 1'b1; s_data = 16'h3C3C; s_clr = 1'b1;
    step(1);
    ck("R8 fast ack cleared", 32'(fa_ack), 0);
    ck("R8 fast req cleared", 32'(fa_req), 0);
    ck("R8 fast cap cleared", 32'(fa_cap), 1);
    ck("R8 fast data cleared", 32'(fa_data), 0);
    ck("R8 slow data cleared", 32'(sl_data), 0);
    ck("R8 slow ack cleared", 32'(sl_ack), 0);
    s_clr = 1'b0; s_req = 1'b0;
    step(5);
    ck("R8 fast no late accept", 32'(fa_ack), 0);
    ck("R8 slow no late accept", 32'(sl_ack), 0);

    // clear on the slow stage's accepting edge
    s_req = 1'b1; s_data = 16'h7E81;
    step(1);
    ck("R2 fast accepts", 32'(fa_ack), 1);
    step(1);
    s_clr = 1'b1;
    step(1);
    ck("R8 slow ack cleared", 32'(sl_ack), 0);
    ck("R8 slow data cleared", 32'(sl_data), 0);
    ck("R8 slow req cleared", 32'(sl_req), 0);
    ck("R8 fast ack cleared", 32'(fa_ack), 0);
    ck("R8 fast cap cleared", 32'(fa_cap), 1);
    s_clr = 1'b0; s_req = 1'b0;
    step(4);
    ck("R8 slow line emptied", 32'(sl_ack), 0);

    // new request in the same cycle as the downstream acknowledge
    s_req = 1'b1; s_data = 16'h1234;
    step(4);
    ck("R2 slow ack", 32'(sl_ack), 1);
    ck("R2 fast ack", 32'(fa_ack), 1);
    ck("R7 slow data", 32'(sl_data), 32'h1234);
    ck("R7 fast data", 32'(fa_data), 32'h1234);
    s_req = 1'b0; s_data = 16'hBEEF; s_ack = 1'b1;
    step(1);
    ck("R4 fast same-cycle accept", 32'(fa_ack), 0);
    ck("R7 fast data", 32'(fa_data), 32'hBEEF);
    ck("R2 slow not yet", 32'(sl_ack), 1);
    ck("R7 slow data held", 32'(sl_data), 32'h1234);
    step(2);
    ck("R2 slow accepts at delay", 32'(sl_ack), 0);
    ck("R7 slow data", 32'(sl_data), 32'hBEEF);
    step(1);
    ck("R3 slow req", 32'(sl_req), 0);
    s_ack = 1'b0;

    // chain with scoreboard
    run_k = 1'b1;
    for (int i = 0; i < N_WORDS; i++) begin
      logic [W-1:0] w;
      w = W'(i * 40503 + 7);
      exp_q.push_back(w);
      k_data = w;
      k_req = ~k_req;
      do @(negedge clk); while (ka0 !== k_req);
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end
    while (n_rcv < N_WORDS) @(negedge clk);
    step(12);
    ck("R9 words received", 32'(n_rcv), 32'(N_WORDS));
    ck("R9 nothing left", 32'(exp_q.size()), 0);
    ck("R6 one ack per request", 32'(n_ack0), 32'(N_WORDS));
    ck("R10 drained phases", 32'({kc0, kc1, kc2}), 32'b010);
    finish_run();
  end

endmodule